// File: doc/BRIEF.md
# Windowed Service Watchdog with Strike Counter

This block supervises a host controller through its serial-port traffic. After it is enabled, the host must produce a service event inside a time window. An event that comes too soon is a violation, and so is no event by the time the window closes. The window has a lower and an upper bound, picked by a 2-bit select input. The bounds are whole multiples of a clock-ticks-per-microsecond parameter. A configuration bit chooses which event counts as service: either any valid read strobe, or only a valid write to the test register. The other strobe is then ignored. The serial decoding sits outside the block, which sees only the strobes.

Violations can report at once, or only after three in a row. A report sets a latched watchdog flag, and the fault-pin request follows that flag. A fault-mode bit decides whether the report also raises a gate-shutdown request. A clear-fault pulse drops the latched flag. Every violation and every correctly timed service restarts the timer.

The controller has three states. IDLE means disabled. CLOSED means the window has not opened yet, so service is early. OPEN means service is accepted. The transitions are:
- IDLE→CLOSED on enable.
- CLOSED→CLOSED on an early service, which is a violation.
- CLOSED→OPEN when the timer reaches the lower bound.
- OPEN→CLOSED on a good service.
- OPEN→CLOSED on timeout, which is a violation.
- any→IDLE when the enable bit is low.

Top module: `spi_window_wdog`

## Requirements
- R1: After reset, wdt_flag, fault_req and shutdown_req are all 0.
- R2: For win_sel 00, 01, 10 and 11, the lower bound is LOW_US×TICKS_PER_US×s clock cycles and the upper bound is HIGH_US×TICKS_PER_US×s clock cycles, with s = 1, 2, 4 and 4 respectively.
- R3: The timer counts the cycles since the last restart. It is 0 in the cycle after a restart edge, and 0 in the cycle after the enabling edge. A service sampled while the timer is in [lower, upper−1] causes no violation and restarts the timer.
- R4: A service sampled while the timer is below the lower bound is a violation and restarts the timer.
- R5: If no service arrives, a violation happens at the edge where the timer would reach the upper bound, and the timer restarts.
- R6: With svc_mode=0, only rd_valid services the watchdog. With svc_mode=1, only wr_test services it. The other strobe has no effect.
- R7: With cnt_mode=0, a single violation sets wdt_flag on the same clock edge.
- R8: With cnt_mode=1, the flag is set only on the third consecutive violation. The strike counter then returns to 0, and a correctly timed service also returns it to 0.
- R9: While wdt_en=0, the block is idle, produces no violations and holds the strike counter at 0.
- R10: wdt_flag stays set until a clear_flt pulse clears it, and a violation in the same cycle as the clear wins. fault_req is equal to wdt_flag.
- R11: shutdown_req is 1 exactly when wdt_flag=1 and flt_mode=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdt_en | input | 1 | Watchdog enable |
| svc_mode | input | 1 | Service type: 0 read strobe, 1 test-register write |
| win_sel | input | 2 | Window select |
| cnt_mode | input | 1 | 0 report on one violation, 1 report on three |
| flt_mode | input | 1 | 1 adds a gate-shutdown request to a report |
| rd_valid | input | 1 | One-cycle strobe, valid read access |
| wr_test | input | 1 | One-cycle strobe, valid write to test register |
| clear_flt | input | 1 | Clear-fault pulse |
| wdt_flag | output | 1 | Latched watchdog fault flag |
| fault_req | output | 1 | Fault-pin request |
| shutdown_req | output | 1 | Gate-shutdown request |

## Verification
A timer that is off by one cycle moves the early/late decision, and the flag appears or fails to appear at the service just before or just after a bound. Services are therefore placed at lower−1, at lower and at upper−1, and the timeout edge is probed in every window. A corrupted strike count shows up as a flag that rises on the second violation, or not until the fourth. A count that survives a disable or a good service shows up the same way in the run that follows. Every error appears on wdt_flag on the very clock edge of the violation.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CLOSED = 2'd1,
        ST_OPEN   = 2'd2
    } wdog_state_t;

    // log2 of the window scale factor for each select code
    function automatic int unsigned win_shift(input logic [1:0] code);
        case (code)
            2'b00:   return 0;
            2'b01:   return 1;
            default: return 2;
        endcase
    endfunction
endpackage

// File: rtl/wdog_limits.sv
module wdog_limits #(
    parameter int unsigned TICKS_PER_US = 10,
    parameter int unsigned LOW_US       = 500,
    parameter int unsigned HIGH_US      = 10000,
    parameter int unsigned TW           = 20
) (
    input  logic [1:0]    win_sel,
    output logic [TW-1:0] lo_lim,
    output logic [TW-1:0] hi_lim
);
    import wdog_pkg::*;

    localparam logic [TW-1:0] LO_BASE = TW'(LOW_US * TICKS_PER_US);
    localparam logic [TW-1:0] HI_BASE = TW'(HIGH_US * TICKS_PER_US);

    always_comb begin
        lo_lim = LO_BASE << win_shift(win_sel);
        hi_lim = HI_BASE << win_shift(win_sel);
    end
endmodule

// File: rtl/wdog_window_fsm.sv
module wdog_window_fsm #(
    parameter int unsigned TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          svc,
    input  logic [TW-1:0] lo_lim,
    input  logic [TW-1:0] hi_lim,
    output logic          viol,
    output logic          good,
    output logic [TW-1:0] timer
);
    import wdog_pkg::*;

    wdog_state_t   state, state_nxt;
    logic [TW-1:0] timer_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            timer <= '0;
        end else begin
            state <= state_nxt;
            timer <= timer_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        timer_nxt = timer + 1'b1;
        viol      = 1'b0;
        good      = 1'b0;
        if (!en) begin
            state_nxt = ST_IDLE;
            timer_nxt = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_nxt = ST_CLOSED;
                    timer_nxt = '0;
                end
                ST_CLOSED: begin
                    if (svc) begin
                        viol      = 1'b1;
                        timer_nxt = '0;
                    end else if (timer >= lo_lim - 1'b1) begin
                        state_nxt = ST_OPEN;
                    end
                end
                ST_OPEN: begin
                    if (svc) begin
                        good      = 1'b1;
                        state_nxt = ST_CLOSED;
                        timer_nxt = '0;
                    end else if (timer >= hi_lim - 1'b1) begin
                        viol      = 1'b1;
                        state_nxt = ST_CLOSED;
                        timer_nxt = '0;
                    end
                end
                default: begin
                    state_nxt = ST_IDLE;
                    timer_nxt = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/wdog_strike.sv
module wdog_strike #(
    parameter int unsigned STRIKES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cnt_mode,
    input  logic viol,
    input  logic good,
    output logic report,
    output logic [$clog2(STRIKES)-1:0] strike_cnt
);
    localparam int unsigned SW = $clog2(STRIKES);
    localparam logic [SW-1:0] LAST = SW'(STRIKES - 1);

    always_comb report = viol && (!cnt_mode || strike_cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       strike_cnt <= '0;
        else if (!en)     strike_cnt <= '0;
        else if (good)    strike_cnt <= '0;
        else if (viol)    strike_cnt <= report ? '0 : strike_cnt + 1'b1;
    end
endmodule

// File: rtl/spi_window_wdog.sv
module spi_window_wdog #(
    parameter int unsigned TICKS_PER_US = 10,
    parameter int unsigned LOW_US       = 500,
    parameter int unsigned HIGH_US      = 10000,
    parameter int unsigned STRIKES      = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wdt_en,
    input  logic       svc_mode,
    input  logic [1:0] win_sel,
    input  logic       cnt_mode,
    input  logic       flt_mode,
    input  logic       rd_valid,
    input  logic       wr_test,
    input  logic       clear_flt,
    output logic       wdt_flag,
    output logic       fault_req,
    output logic       shutdown_req
);
    localparam int unsigned TW = $clog2(HIGH_US * TICKS_PER_US * 4 + 1);
    localparam int unsigned SW = $clog2(STRIKES);

    logic [TW-1:0] lo_lim, hi_lim, timer;
    logic          svc, viol, good, report;
    logic [SW-1:0] strike_cnt;

    always_comb svc = svc_mode ? wr_test : rd_valid;

    wdog_limits #(.TICKS_PER_US(TICKS_PER_US), .LOW_US(LOW_US),
                  .HIGH_US(HIGH_US), .TW(TW)) limits_i (
        .win_sel(win_sel), .lo_lim(lo_lim), .hi_lim(hi_lim));

    wdog_window_fsm #(.TW(TW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .en(wdt_en), .svc(svc),
        .lo_lim(lo_lim), .hi_lim(hi_lim),
        .viol(viol), .good(good), .timer(timer));

    wdog_strike #(.STRIKES(STRIKES)) strike_i (
        .clk(clk), .rst_n(rst_n), .en(wdt_en), .cnt_mode(cnt_mode),
        .viol(viol), .good(good), .report(report), .strike_cnt(strike_cnt));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         wdt_flag <= 1'b0;
        else if (report)    wdt_flag <= 1'b1;
        else if (clear_flt) wdt_flag <= 1'b0;
    end

    always_comb begin
        fault_req    = wdt_flag;
        shutdown_req = wdt_flag && flt_mode;
    end
endmodule

// File: rtl/spi_window_wdog_chk.sv
module spi_window_wdog_chk #(
    parameter int unsigned SW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wdt_en,
    input logic          clear_flt,
    input logic          report,
    input logic [SW-1:0] strike_cnt,
    input logic          wdt_flag,
    input logic          fault_req,
    input logic          shutdown_req
);
    assert_clear_drops_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_flt && !report) |=> !wdt_flag);

    assert_flag_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_flag && !clear_flt) |=> wdt_flag);

    assert_shutdown_needs_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> fault_req);

    assert_disable_clears_strikes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_en |=> (strike_cnt == '0));

    assert_strike_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strike_cnt <= SW'(2));
endmodule

bind spi_window_wdog spi_window_wdog_chk #(.SW(SW)) chk_i (
    .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .clear_flt(clear_flt),
    .report(report), .strike_cnt(strike_cnt), .wdt_flag(wdt_flag),
    .fault_req(fault_req), .shutdown_req(shutdown_req));

// File: tb/spi_window_wdog_tb_top.sv
module spi_window_wdog_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TPU = 2;
    localparam int LOW = 5;
    localparam int HIGH = 40;

    logic clk = 0, rst_n = 0;
    logic wdt_en = 0, svc_mode = 0, cnt_mode = 0, flt_mode = 0;
    logic [1:0] win_sel = 0;
    logic rd_valid = 0, wr_test = 0, clear_flt = 0;
    logic wdt_flag, fault_req, shutdown_req;

    int n_checks = 0, n_fail = 0, tpos = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_window_wdog #(.TICKS_PER_US(TPU), .LOW_US(LOW), .HIGH_US(HIGH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .svc_mode(svc_mode),
        .win_sel(win_sel), .cnt_mode(cnt_mode), .flt_mode(flt_mode),
        .rd_valid(rd_valid), .wr_test(wr_test), .clear_flt(clear_flt),
        .wdt_flag(wdt_flag), .fault_req(fault_req), .shutdown_req(shutdown_req));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_flag(input bit exp, input string tag);
        check(wdt_flag == exp, tag, int'(wdt_flag), int'(exp));
        check(fault_req == exp, {tag, " R10 fault_req"}, int'(fault_req), int'(exp));
        check(shutdown_req == (exp && flt_mode), {tag, " R11 shutdown_req"},
              int'(shutdown_req), int'(exp && flt_mode));
    endtask

    task automatic step(input int n);
        if (n > 0) begin
            repeat (n) @(posedge clk);
            @(negedge clk);
        end
        tpos += n;
    endtask

    task automatic restart();
        wdt_en = 0; clear_flt = 1; step(1);
        clear_flt = 0; wdt_en = 1; step(1);
        tpos = 0;
    endtask

    // service so that it is sampled while the timer equals t
    task automatic svc_at(input int t);
        step(t - tpos);
        if (svc_mode) wr_test = 1; else rd_valid = 1;
        step(1);
        wr_test = 0; rd_valid = 0;
        tpos = 0;
    endtask

    task automatic wrong_strobe();
        if (svc_mode) rd_valid = 1; else wr_test = 1;
        step(1);
        wr_test = 0; rd_valid = 0;
    endtask

    function automatic int scale(input int w);
        return (w == 0) ? 1 : (w == 1) ? 2 : 4;
    endfunction

    initial begin
        @(negedge clk);
        chk_flag(0, "R1 during reset");
        step(2);
        rst_n = 1;
        step(1);
        chk_flag(0, "R1 after reset");

        // R9: disabled block ignores services entirely
        rd_valid = 1; step(3); rd_valid = 0;
        chk_flag(0, "R9 disabled, services ignored");

        for (int m = 0; m < 2; m++) begin
            for (int w = 0; w < 4; w++) begin
                int lo, hi;
                lo = LOW * TPU * scale(w);
                hi = HIGH * TPU * scale(w);
                svc_mode = m[0]; win_sel = w[1:0]; cnt_mode = 0;
                flt_mode = m[0] ^ w[0];
                restart();
                chk_flag(0, "R10 flag cleared");
                svc_at(lo);
                chk_flag(0, "R3 R2 service at lower bound");
                svc_at(hi - 1);
                chk_flag(0, "R3 R2 service at upper-1");
                wrong_strobe();
                svc_at(lo);
                chk_flag(0, "R6 other strobe ignored");
                svc_at(lo - 1);
                chk_flag(1, "R4 R7 R2 early service at lower-1");
                restart();
                step(hi - 1);
                chk_flag(0, "R5 R2 no timeout at upper-1");
                step(1);
                chk_flag(1, "R5 R2 timeout at upper bound");
                svc_at(lo - 1);
                clear_flt = 1; step(1); clear_flt = 0;
                chk_flag(0, "R10 clear while running");
                svc_at(lo);
                chk_flag(0, "R3 restart after timeout");
            end
        end

        for (int m = 0; m < 2; m++) begin
            int lo;
            svc_mode = m[0]; win_sel = 0; cnt_mode = 1; flt_mode = 1;
            lo = LOW * TPU;
            restart();
            svc_at(tpos); chk_flag(0, "R8 first strike");
            svc_at(tpos); chk_flag(0, "R8 second strike");
            svc_at(tpos); chk_flag(1, "R8 third strike reports");
            clear_flt = 1; step(1); clear_flt = 0;
            chk_flag(0, "R10 cleared");
            svc_at(tpos); svc_at(tpos);
            chk_flag(0, "R8 counter restarted after report");
            svc_at(tpos);
            chk_flag(1, "R8 third after report");
            restart();
            svc_at(tpos); svc_at(tpos);
            svc_at(lo);
            svc_at(tpos); svc_at(tpos);
            chk_flag(0, "R8 good service cleared count");
            svc_at(tpos);
            chk_flag(1, "R8 third after good");
            restart();
            svc_at(tpos); svc_at(tpos);
            wdt_en = 0; step(1); wdt_en = 1; step(1); tpos = 0;
            svc_at(tpos); svc_at(tpos);
            chk_flag(0, "R9 disable cleared count");
            svc_at(tpos);
            chk_flag(1, "R9 third after re-enable");
            // R10: violation in same cycle as clear wins
            svc_at(tpos); svc_at(tpos);
            clear_flt = 1; svc_at(tpos); clear_flt = 0;
            chk_flag(1, "R10 violation beats clear");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule